// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (clock and open-drain data) that holds the configuration and status registers of a display link transmitter. A host writes control fields such as power state, latch edge, bus width, clock type, sync enables and the monitor-pin source. It reads back constant identification bytes, frequency limits and live status.

The bus lines are oversampled with the system clock, so the block needs no clock of its own from the bus. Transfers are single bytes only. A write is the device address, then a register pointer, then one data byte. A read either returns the byte at the pointer already held, or sets the pointer first and then uses a repeated start. A status bit drops low when a selected detect input changes level. Software restores it by writing a one. A multiplexer routes that bit, or one of the raw detect inputs, to a monitor pin.

Top module: `cfg_twowire_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address formed by 0111 followed by the three address-select pins (38h to 3Fh). For any other address it leaves data released and ignores the rest of the transfer.
- R2: The address-select pins are captured when the first address byte on the bus completes, whether or not that byte addresses this slave. Later pin changes do not alter the address.
- R3: A write of address byte (R/W=0), register pointer and one data byte gets an acknowledge on each of the three bytes. The data lands in the addressed register.
- R4: A combined read (pointer write, repeated start, address byte with R/W=1) returns the addressed register, most significant bit first.
- R5: A read without a pointer phase returns the register at the pointer held from the previous access.
- R6: Addresses 00h to 07h read 05h, 13h, 24h, 67h, 00h, 00h, 19h and 55h. Writes to them have no effect.
- R7: After reset, register 08h reads 0Bh and register 09h reads 0Bh. The outputs are power-on=1, falling-edge=1, dual-bus=0, single-ended clock=1, HSYNC enable=1, VSYNC enable=1, interrupt source=0, monitor select=001, and the monitor pin is high.
- R8: Register 08h holds power-on (bit 0), falling-edge (bit 1), dual-bus (bit 2) and single-ended clock (bit 3). Register 09h holds HSYNC enable (bit 0), VSYNC enable (bit 1), interrupt source (bit 2) and monitor select (bits 5:3). Unused bits read 0 and ignore writes. Pointers above 0Fh read 00h and ignore writes.
- R9: Register 0Ah reads {hot-plug, low-swing, receiver-sense} in bits 3:1 and the interrupt bit in bit 0. The interrupt bit is 1 at reset. It goes to 0 when the selected detect input changes level (source 0 = receiver-sense, 1 = hot-plug). Writing 1 to bit 0 sets it back to 1, and writing 0 leaves it unchanged.
- R10: The monitor pin is driven according to monitor select: 000 gives 1, 001 gives the interrupt bit, 010 gives receiver-sense, 011 gives hot-plug, and 1xx gives 1.
- R11: The master may answer a read byte with either ACK or NACK. In both cases the transfer ends and the next transfer works normally.
- R12: There is no auto-increment. A second data byte in one write is not acknowledged and not stored, and repeated reads return the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| addr_sel_i | input | 3 | Low three bits of the slave address |
| rcv_sense_i | input | 1 | Receiver-present status |
| low_swing_i | input | 1 | Low-swing input detect status |
| hotplug_i | input | 1 | Hot-plug detect status |
| pwr_on_o | output | 1 | Output drivers enabled |
| edge_fall_o | output | 1 | Primary latch edge is falling |
| dual_bus_o | output | 1 | Two input buses in use |
| clk_single_o | output | 1 | Input clock is single-ended |
| hs_en_o | output | 1 | HSYNC passed through |
| vs_en_o | output | 1 | VSYNC passed through |
| irq_src_o | output | 1 | Interrupt source select |
| mon_sel_o | output | 3 | Monitor pin source select |
| mon_pin_o | output | 1 | Monitor/interrupt pin level |

## Verification
The hardest case to reach is the address capture. It happens once, on the first address byte seen after reset, so it can only be observed by running a transfer to a foreign address first, then moving the pins and showing that the slave still answers only the originally captured address. The bench does exactly that before any other traffic. A second hard case is the interrupt source switch, which must not raise a false interrupt. The bench toggles the deselected input and reads the status register, then toggles the selected one.

// File: rtl/cfg_twowire_pkg.sv
package cfg_twowire_pkg;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_REG,
    LK_REG_ACK,
    LK_WDAT,
    LK_WDAT_ACK,
    LK_RDAT,
    LK_RACK
  } link_state_t;

  localparam int unsigned BYTE_BITS = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b0111;

  localparam logic [7:0] ADR_CTRL_A = 8'h08;
  localparam logic [7:0] ADR_CTRL_B = 8'h09;
  localparam logic [7:0] ADR_STAT   = 8'h0A;

  // control A fields
  localparam int unsigned CA_PWR    = 0;
  localparam int unsigned CA_EDGE   = 1;
  localparam int unsigned CA_DUAL   = 2;
  localparam int unsigned CA_CLKSE  = 3;
  localparam int unsigned CA_WIDTH  = 4;
  // control B fields
  localparam int unsigned CB_HS     = 0;
  localparam int unsigned CB_VS     = 1;
  localparam int unsigned CB_SRC    = 2;
  localparam int unsigned CB_MON_LO = 3;
  localparam int unsigned CB_WIDTH  = 6;

  localparam logic [CA_WIDTH-1:0] CA_RESET = 4'b1011;
  localparam logic [CB_WIDTH-1:0] CB_RESET = 6'b001011;

  localparam logic [2:0] MON_FORCE_HI = 3'b000;
  localparam logic [2:0] MON_IRQ      = 3'b001;
  localparam logic [2:0] MON_RSENSE   = 3'b010;
  localparam logic [2:0] MON_HPLUG    = 3'b011;

  function automatic logic [7:0] const_byte(input logic [2:0] a);
    logic [7:0] v;
    case (a)
      3'd0:    v = 8'h05;
      3'd1:    v = 8'h13;
      3'd2:    v = 8'h24;
      3'd3:    v = 8'h67;
      3'd6:    v = 8'h19;
      3'd7:    v = 8'h55;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tw_sync_vec.sv
module tw_sync_vec #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= RST_VAL;
          else        pipe_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= RST_VAL;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
  import cfg_twowire_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_s,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output logic       addr_lock,
  output logic [2:0] addr_pins
);

  localparam int unsigned CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_BITS);

  link_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0] shf_q, shf_d;
  logic [7:0] ptr_q, ptr_d;
  logic [2:0] pins_q, pins_d;
  logic rw_q, rw_d, oe_q, oe_d, lock_q, lock_d, wr_q, wr_d;
  logic match;

  assign match = (shf_q[7:1] == {DEV_PREFIX, (lock_q ? pins_q : addr_sel_i)});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    shf_d  = shf_q;
    ptr_d  = ptr_q;
    pins_d = pins_q;
    rw_d   = rw_q;
    oe_d   = oe_q;
    lock_d = lock_q;
    wr_d   = 1'b0;
    if (stop_det) begin
      st_d = LK_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d  = LK_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        LK_ADDR, LK_REG, LK_WDAT: begin
          if (scl_rise) begin
            shf_d = {shf_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (st_q == LK_ADDR) begin
              if (!lock_q) begin
                lock_d = 1'b1;
                pins_d = addr_sel_i;
              end
              if (match) begin
                oe_d = 1'b1;
                rw_d = shf_q[0];
                st_d = LK_ADDR_ACK;
              end else begin
                st_d = LK_IDLE;
              end
            end else if (st_q == LK_REG) begin
              ptr_d = shf_q;
              oe_d  = 1'b1;
              st_d  = LK_REG_ACK;
            end else begin
              wr_d = 1'b1;
              oe_d = 1'b1;
              st_d = LK_WDAT_ACK;
            end
          end
        end
        LK_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              shf_d = rd_data;
              oe_d  = ~rd_data[7];
              cnt_d = '0;
              st_d  = LK_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = LK_REG;
            end
          end
        end
        LK_REG_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = LK_WDAT;
          end
        end
        LK_WDAT_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = LK_IDLE;
          end
        end
        LK_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              oe_d = 1'b0;
              st_d = LK_RACK;
            end else begin
              shf_d = {shf_q[6:0], 1'b0};
              oe_d  = ~shf_q[6];
            end
          end
        end
        LK_RACK: begin
          if (scl_rise) st_d = LK_IDLE;
        end
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      cnt_q  <= '0;
      shf_q  <= '0;
      ptr_q  <= '0;
      pins_q <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      lock_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      shf_q  <= shf_d;
      ptr_q  <= ptr_d;
      pins_q <= pins_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      lock_q <= lock_d;
      wr_q   <= wr_d;
    end
  end

  assign sda_oe    = oe_q;
  assign wr_en     = wr_q;
  assign wr_addr   = ptr_q;
  assign wr_data   = shf_q;
  assign ptr       = ptr_q;
  assign addr_lock = lock_q;
  assign addr_pins = pins_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_twowire_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  input  logic       rs_s,
  input  logic       ls_s,
  input  logic       hp_s,
  output logic [7:0] rd_data,
  output logic [CA_WIDTH-1:0] ctla,
  output logic [CB_WIDTH-1:0] ctlb,
  output logic       irq_bit,
  output logic       mon_pin
);

  localparam int unsigned ARM_MAX = SYNC_STAGES + 1;
  localparam int unsigned AW      = $clog2(ARM_MAX + 1);
  localparam logic [AW-1:0] ARM_END = AW'(ARM_MAX);

  logic [CA_WIDTH-1:0] ctla_q, ctla_d;
  logic [CB_WIDTH-1:0] ctlb_q, ctlb_d;
  logic [AW-1:0] arm_q, arm_d;
  logic irq_q, irq_d, pin_q, pin_d, rs_p_q, hp_p_q;
  logic armed, rs_chg, hp_chg, mon_chg, clr_req;
  logic [2:0] mon_sel;

  assign armed   = (arm_q == ARM_END);
  assign rs_chg  = armed & (rs_s ^ rs_p_q);
  assign hp_chg  = armed & (hp_s ^ hp_p_q);
  assign mon_chg = ctlb_q[CB_SRC] ? hp_chg : rs_chg;
  assign clr_req = wr_en & (wr_addr == ADR_STAT) & wr_data[0];
  assign mon_sel = ctlb_q[CB_MON_LO +: 3];

  always_comb begin
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    if (wr_en && wr_addr == ADR_CTRL_A) ctla_d = wr_data[CA_WIDTH-1:0];
    if (wr_en && wr_addr == ADR_CTRL_B) ctlb_d = wr_data[CB_WIDTH-1:0];
    arm_d = armed ? arm_q : arm_q + 1'b1;
    irq_d = irq_q;
    if (clr_req) irq_d = 1'b1;
    if (mon_chg) irq_d = 1'b0;
    case (mon_sel)
      MON_IRQ:    pin_d = irq_q;
      MON_RSENSE: pin_d = rs_s;
      MON_HPLUG:  pin_d = hp_s;
      default:    pin_d = 1'b1;
    endcase
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr[7:4] == 4'h0) begin
      if (rd_addr[3] == 1'b0) begin
        rd_data = const_byte(rd_addr[2:0]);
      end else if (rd_addr == ADR_CTRL_A) begin
        rd_data = {{(8-CA_WIDTH){1'b0}}, ctla_q};
      end else if (rd_addr == ADR_CTRL_B) begin
        rd_data = {{(8-CB_WIDTH){1'b0}}, ctlb_q};
      end else if (rd_addr == ADR_STAT) begin
        rd_data = {4'h0, hp_s, ls_s, rs_s, irq_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q <= CA_RESET;
      ctlb_q <= CB_RESET;
      arm_q  <= '0;
      irq_q  <= 1'b1;
      pin_q  <= 1'b1;
      rs_p_q <= 1'b0;
      hp_p_q <= 1'b0;
    end else begin
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
      arm_q  <= arm_d;
      irq_q  <= irq_d;
      pin_q  <= pin_d;
      rs_p_q <= rs_s;
      hp_p_q <= hp_s;
    end
  end

  assign ctla    = ctla_q;
  assign ctlb    = ctlb_q;
  assign irq_bit = irq_q;
  assign mon_pin = pin_q;

endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
  import cfg_twowire_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_sel_i,
  input  logic       rcv_sense_i,
  input  logic       low_swing_i,
  input  logic       hotplug_i,
  output logic       pwr_on_o,
  output logic       edge_fall_o,
  output logic       dual_bus_o,
  output logic       clk_single_o,
  output logic       hs_en_o,
  output logic       vs_en_o,
  output logic       irq_src_o,
  output logic [2:0] mon_sel_o,
  output logic       mon_pin_o
);

  logic [1:0] rst_pipe_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [1:0] bus_s;
  logic [2:0] stat_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, addr_lock, irq_bit;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;
  logic [2:0] addr_pins;
  logic [CA_WIDTH-1:0] ctla;
  logic [CB_WIDTH-1:0] ctlb;

  tw_sync_vec #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i({scl_i, sda_i}), .q_o(bus_s));

  tw_sync_vec #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_stat_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i({hotplug_i, low_swing_i, rcv_sense_i}), .q_o(stat_s));

  tw_cond_detect u_cond (
    .clk(clk), .rst_n(rst_sync_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

  tw_link_fsm u_link (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(bus_s[0]),
    .addr_sel_i(addr_sel_i), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr),
    .addr_lock(addr_lock), .addr_pins(addr_pins));

  cfg_regfile #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rs_s(stat_s[0]), .ls_s(stat_s[1]),
    .hp_s(stat_s[2]), .rd_data(rd_data), .ctla(ctla), .ctlb(ctlb),
    .irq_bit(irq_bit), .mon_pin(mon_pin_o));

  assign pwr_on_o     = ctla[CA_PWR];
  assign edge_fall_o  = ctla[CA_EDGE];
  assign dual_bus_o   = ctla[CA_DUAL];
  assign clk_single_o = ctla[CA_CLKSE];
  assign hs_en_o      = ctlb[CB_HS];
  assign vs_en_o      = ctlb[CB_VS];
  assign irq_src_o    = ctlb[CB_SRC];
  assign mon_sel_o    = ctlb[CB_MON_LO +: 3];

endmodule

// File: rtl/cfg_twowire_chk.sv
module cfg_twowire_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       wr_clr,
  input logic       irq_bit,
  input logic [2:0] mon_sel,
  input logic       mon_pin,
  input logic       addr_lock,
  input logic [2:0] addr_pins
);

  // R1: data line drive changes only after a clock fall (or a bus condition)
  p_oe_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> $past(scl_fall));

  // R2: captured address bits never move once captured
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_lock && $past(addr_lock)) |-> $stable(addr_pins));

  // R12: one write strobe per transfer byte
  p_single_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R9: interrupt bit returns high only after a write of one
  p_irq_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_bit) |-> $past(wr_en && wr_addr == 8'h0A && wr_clr));

  // R10: forced-high and reserved selections hold the pin high
  p_mon_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 3'b000) |=> mon_pin);
  p_mon_rsv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_sel[2] |=> mon_pin);

endmodule

bind cfg_twowire_slave cfg_twowire_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_clr(wr_data[0]), .irq_bit(irq_bit), .mon_sel(mon_sel_o), .mon_pin(mon_pin_o),
  .addr_lock(addr_lock), .addr_pins(addr_pins));

// File: tb/sim_cfg_twowire_slave.sv
module sim_cfg_twowire_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] addr_sel = 3'b101;
  logic rs = 1'b0, ls = 1'b0, hp = 1'b0;
  logic sda_oe, pwr_on, edge_fall, dual_bus, clk_single, hs_en, vs_en, irq_src, mon_pin;
  logic [2:0] mon_sel;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cfg_twowire_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .rcv_sense_i(rs), .low_swing_i(ls), .hotplug_i(hp),
    .pwr_on_o(pwr_on), .edge_fall_o(edge_fall), .dual_bus_o(dual_bus),
    .clk_single_o(clk_single), .hs_en_o(hs_en), .vs_en_o(vs_en), .irq_src_o(irq_src),
    .mon_sel_o(mon_sel), .mon_pin_o(mon_pin));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic hq(); repeat (10) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    m_sda = b; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); b = sda_line; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~mack);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq(); hq();
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                        output logic [2:0] k);
    k = 3'b000;
    bus_start();
    byte_out({dev, 1'b0}, k[2]);
    if (k[2]) begin
      byte_out(a, k[1]);
      byte_out(d, k[0]);
    end
    bus_stop();
  endtask

  task automatic rd_reg(input logic [6:0] dev, input logic [7:0] a, input logic mack,
                        output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    d = 8'hxx;
    bus_start();
    byte_out({dev, 1'b0}, k0);
    byte_out(a, k1);
    bus_start();
    byte_out({dev, 1'b1}, k2);
    ok = k0 & k1 & k2;
    if (k2) byte_in(d, mack);
    bus_stop();
  endtask

  task automatic rd_cur(input logic [6:0] dev, output logic [7:0] d, output logic ok);
    d = 8'hxx;
    bus_start();
    byte_out({dev, 1'b1}, ok);
    if (ok) byte_in(d, 1'b0);
    bus_stop();
  endtask

  localparam logic [6:0] DEV = 7'h3D;

  task automatic t_reset();
    chk("R7 ctrl A outputs", {4'h0, clk_single, dual_bus, edge_fall, pwr_on}, 8'h0B);
    chk("R7 ctrl B outputs", {2'b0, mon_sel, irq_src, vs_en, hs_en}, 8'h0B);
    chk("R7 monitor pin", {7'h0, mon_pin}, 8'h01);
    chk("R7 data released", {7'h0, sda_oe}, 8'h00);
  endtask

  task automatic t_address();
    logic [2:0] k; logic [7:0] d; logic ok;
    wr_reg(7'h38, 8'h08, 8'h00, k);
    chk("R1 foreign address not acked", {5'h0, k}, 8'h00);
    chk("R1 foreign write ignored", {7'h0, pwr_on}, 8'h01);
    addr_sel = 3'b010;
    wr_reg(7'h3A, 8'h08, 8'h00, k);
    chk("R2 new pin address ignored", {5'h0, k}, 8'h00);
    rd_reg(DEV, 8'h00, 1'b0, d, ok);
    chk("R2 captured address acked", {7'h0, ok}, 8'h01);
    chk("R2 captured address read", d, 8'h05);
  endtask

  task automatic t_ids();
    logic [7:0] exp [8] = '{8'h05, 8'h13, 8'h24, 8'h67, 8'h00, 8'h00, 8'h19, 8'h55};
    logic [7:0] d; logic ok;
    for (int a = 0; a < 8; a++) begin
      rd_reg(DEV, 8'(a), 1'b0, d, ok);
      chk($sformatf("R6 R4 const byte %0d", a), d, exp[a]);
    end
    rd_reg(DEV, 8'h08, 1'b0, d, ok);
    chk("R7 reg 08 reset", d, 8'h0B);
    rd_reg(DEV, 8'h09, 1'b0, d, ok);
    chk("R7 reg 09 reset", d, 8'h0B);
    rd_reg(DEV, 8'h07, 1'b0, d, ok);
    rd_cur(DEV, d, ok);
    chk("R5 current pointer read", d, 8'h55);
  endtask

  task automatic t_write();
    logic [2:0] k; logic [7:0] d; logic ok;
    wr_reg(DEV, 8'h08, 8'h00, k);
    chk("R3 three acks", {5'h0, k}, 8'h07);
    chk("R8 ctrl A cleared outputs", {4'h0, clk_single, dual_bus, edge_fall, pwr_on}, 8'h00);
    rd_reg(DEV, 8'h08, 1'b0, d, ok);
    chk("R3 readback 08", d, 8'h00);
    wr_reg(DEV, 8'h08, 8'hFF, k);
    rd_reg(DEV, 8'h08, 1'b0, d, ok);
    chk("R8 unused bits of 08", d, 8'h0F);
    chk("R8 ctrl A set outputs", {4'h0, clk_single, dual_bus, edge_fall, pwr_on}, 8'h0F);
    wr_reg(DEV, 8'h09, 8'hFF, k);
    rd_reg(DEV, 8'h09, 1'b0, d, ok);
    chk("R8 unused bits of 09", d, 8'h3F);
    wr_reg(DEV, 8'h09, 8'h0B, k);
    wr_reg(DEV, 8'h08, 8'h0B, k);
    wr_reg(DEV, 8'h00, 8'hAA, k);
    rd_reg(DEV, 8'h00, 1'b0, d, ok);
    chk("R6 constant not writable", d, 8'h05);
    wr_reg(DEV, 8'h20, 8'h77, k);
    rd_reg(DEV, 8'h20, 1'b0, d, ok);
    chk("R8 pointer above 0F reads zero", d, 8'h00);
  endtask

  task automatic t_single();
    logic k0, k1, k2, k3; logic [7:0] d; logic ok;
    bus_start();
    byte_out({DEV, 1'b0}, k0);
    byte_out(8'h09, k1);
    byte_out(8'h03, k2);
    byte_out(8'h1B, k3);
    bus_stop();
    chk("R12 second data byte not acked", {6'h0, k2, k3}, 8'h02);
    rd_reg(DEV, 8'h09, 1'b0, d, ok);
    chk("R12 first byte kept", d, 8'h03);
    wr_reg(DEV, 8'h09, 8'h0B, {k0, k1, k2});
  endtask

  task automatic t_ack_end();
    logic [7:0] d; logic ok;
    rd_reg(DEV, 8'h06, 1'b1, d, ok);
    chk("R11 read answered with ACK", d, 8'h19);
    rd_cur(DEV, d, ok);
    chk("R11 R12 next read after ACK", d, 8'h19);
    rd_cur(DEV, d, ok);
    chk("R12 no auto-increment", d, 8'h19);
  endtask

  task automatic t_irq();
    logic [2:0] k; logic [7:0] d; logic ok;
    rs = 1'b1; repeat (10) @(negedge clk);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 irq on receiver-sense change", d, 8'h02);
    chk("R10 pin follows irq", {7'h0, mon_pin}, 8'h00);
    wr_reg(DEV, 8'h0A, 8'h00, k);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 write zero keeps irq", d, 8'h02);
    wr_reg(DEV, 8'h0A, 8'h01, k);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 write one clears irq", d, 8'h03);
    chk("R10 pin high after clear", {7'h0, mon_pin}, 8'h01);
    wr_reg(DEV, 8'h09, 8'h0F, k);
    rs = 1'b0; repeat (10) @(negedge clk);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 deselected source ignored", d, 8'h01);
    hp = 1'b1; repeat (10) @(negedge clk);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 irq on hot-plug change", d, 8'h08);
    wr_reg(DEV, 8'h0A, 8'h01, k);
    ls = 1'b1; repeat (10) @(negedge clk);
    rd_reg(DEV, 8'h0A, 1'b0, d, ok);
    chk("R9 status bits", d, 8'h0D);
  endtask

  task automatic t_mux();
    logic [2:0] k;
    wr_reg(DEV, 8'h09, 8'h13, k);
    chk("R10 sel 010 low", {7'h0, mon_pin}, 8'h00);
    rs = 1'b1; repeat (10) @(negedge clk);
    chk("R10 sel 010 high", {7'h0, mon_pin}, 8'h01);
    wr_reg(DEV, 8'h09, 8'h1B, k);
    chk("R10 sel 011 high", {7'h0, mon_pin}, 8'h01);
    hp = 1'b0; repeat (10) @(negedge clk);
    chk("R10 sel 011 low", {7'h0, mon_pin}, 8'h00);
    wr_reg(DEV, 8'h09, 8'h03, k);
    chk("R10 sel 000 forced high", {7'h0, mon_pin}, 8'h01);
    wr_reg(DEV, 8'h09, 8'h23, k);
    rs = 1'b0; repeat (10) @(negedge clk);
    chk("R10 sel 1xx high", {7'h0, mon_pin}, 8'h01);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_address();
    t_ids();
    t_write();
    t_single();
    t_ack_end();
    t_irq();
    t_mux();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule